// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block catches a program that has stopped servicing it. A prescaler built as a free-running up-counter produces one tick every 16 or every 128 bus clocks, depending on a select bit. Each tick lowers a 15-bit counter by one. When a tick arrives while the counter already reads zero, the block raises a one-clock interrupt request, and on the same edge the counter returns to all ones. Software keeps the timer from expiring by writing to its start register before the count runs out. With the default sizes, one full period is the divide ratio times 32768 bus clocks.

The timer does nothing after reset until software first writes the start register. From then on it cannot be stopped; only a system reset brings it back to idle. A restart write reloads the counter but leaves the prescaler where it is, so the first tick after a restart can come early by up to one prescaler period. While the hold input is high, neither the prescaler nor the counter moves. Bus address decoding, interrupt routing and reset generation belong to the surrounding logic.

Top module: `wdt_prescaled`

## Requirements
- R1: While reset is applied, and afterwards until the first start write, `running` reads 0, `count` holds all ones (2^CNT_W-1) and `irq` stays 0. Toggling `div_sel` or `hold` during this time has no effect.
- R2: A cycle with `start_wr` high sets `running` to 1 and `count` to all ones on the next clock edge. If a tick lands in the same cycle, the write wins and no interrupt is raised.
- R3: The prescaler counts bus clocks only while `running` is 1, and its ticks lower `count` by one. Ticks are DIV_LO clocks apart when `div_sel`=0 and DIV_HI clocks apart when `div_sel`=1. Both ratios are powers of two. A tick fires when the low log2(ratio) bits of the shared prescaler counter are all ones. After a reset followed by a start write, the first decrement lands exactly one ratio of clock edges after the start edge.
- R4: `irq` is high for exactly one cycle, in the cycle where a tick arrives while `count` is 0. On that edge `count` reloads to all ones instead of wrapping. Successive interrupts are ratio×2^CNT_W clocks apart.
- R5: A start write does not clear the prescaler. A restart issued in the cycle right after a decrement sees its next decrement after ratio−1 edges, counted from the start edge.
- R6: While `hold` is 1, both the prescaler and `count` are frozen. A hold lasting H cycles pushes the next interrupt back by exactly H clocks.
- R7: Once `running` is 1 it stays 1 until reset. A start write while running only reloads `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Freezes the prescaler and the counter while high |
| start_wr | input | 1 | One-cycle strobe for a write to the start register |
| div_sel | input | 1 | Prescaler ratio: 0 gives DIV_LO, 1 gives DIV_HI |
| irq | output | 1 | One-cycle watchdog interrupt request |
| count | output | CNT_W | Current value of the down-counter |
| running | output | 1 | 1 once the timer has been started |

## Verification
The checker watches the following on every cycle:
- the idle state before the first start write;
- that `running` never drops once set;
- the reload after a start write or an interrupt;
- that an interrupt appears only while the count reads zero;
- that the count is frozen under hold;
- that the count moves in steps of at most one.

Some properties depend on where the prescaler happens to be, so only the bench's scenarios can show them: the exact spacing of ticks for each ratio, the full interrupt period, the extra delay caused by a hold, and the early first tick after a restart. The bench runs these with a 4-bit counter and ratios of 4 and 16, so that every period is short.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int CNT_W  = 15,
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             start_wr,
  input  logic             div_sel,
  output logic             irq,
  output logic [CNT_W-1:0] count,
  output logic             running
);
  localparam int PRE_W = $clog2(DIV_HI);
  localparam logic [PRE_W-1:0] MASK_LO = PRE_W'(DIV_LO - 1);
  localparam logic [PRE_W-1:0] MASK_HI = PRE_W'(DIV_HI - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;
  logic             advance;
  logic             tick;

  assign mask    = div_sel ? MASK_HI : MASK_LO;
  assign advance = running && !hold;
  assign tick    = advance && ((pre & mask) == mask);
  assign irq     = tick && (count == '0) && !start_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      count   <= CNT_MAX;
      running <= 1'b0;
    end else begin
      if (advance) pre <= pre + 1'b1;
      if (start_wr) begin
        running <= 1'b1;
        count   <= CNT_MAX;
      end else if (tick) begin
        count <= (count == '0) ? CNT_MAX : count - 1'b1;
      end
    end
  end
endmodule

module wdt_prescaled_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             hold,
  input logic             start_wr,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic             running
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !running |-> (count == CNT_MAX && !irq));

  a_r2_start_reload: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> (running && count == CNT_MAX));

  a_r2_start_masks_irq: assert property (@(posedge clk) disable iff (rst)
    start_wr |-> !irq);

  a_r4_irq_at_zero: assert property (@(posedge clk) disable iff (rst)
    irq |-> (count == '0 && running));

  a_r4_irq_reload: assert property (@(posedge clk) disable iff (rst)
    irq |=> (count == CNT_MAX && !irq));

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (!start_wr && !irq) |=> (count == $past(count) || count == $past(count) - 1'b1));

  a_r6_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    (hold && !start_wr) |=> $stable(count));

  a_r7_no_stop: assert property (@(posedge clk) disable iff (rst)
    running |=> running);
endmodule

bind wdt_prescaled wdt_prescaled_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .start_wr(start_wr),
  .irq(irq), .count(count), .running(running)
);

// File: tb/wdt_prescaled_tb.sv
module wdt_prescaled_tb;
  localparam int CNT_W  = 4;
  localparam int DIV_LO = 4;
  localparam int DIV_HI = 16;
  localparam int MAXV   = (1 << CNT_W) - 1;
  localparam int LIMIT  = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1, hold = 1'b0, start_wr = 1'b0, div_sel = 1'b0;
  logic irq, running;
  logic [CNT_W-1:0] count;
  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  wdt_prescaled #(.CNT_W(CNT_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_dut (
    .clk(clk), .rst(rst), .hold(hold), .start_wr(start_wr), .div_sel(div_sel),
    .irq(irq), .count(count), .running(running)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<=100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic step;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1; start_wr = 1'b0; hold = 1'b0;
    step; step;
    rst = 1'b0;
    step;
  endtask

  task automatic start_pulse;
    start_wr = 1'b1;
    step;
    start_wr = 1'b0;
  endtask

  task automatic steps_to_change(output int n);
    logic [CNT_W-1:0] v;
    v = count; n = 0;
    while (count == v && n < LIMIT) begin step; n++; end
  endtask

  task automatic wait_irq;
    int n;
    n = 0;
    while (!irq && n < LIMIT) begin step; n++; end
  endtask

  task automatic steps_to_irq(output int n);
    n = 0;
    step; n++;
    while (!irq && n < LIMIT) begin step; n++; end
  endtask

  initial begin
    int n;
    int bad;
    step;
    do_reset;
    // R1: reset state
    chk(running == 1'b0, "R1 running after reset", running, 0);
    chk(count == MAXV, "R1 count after reset", count, MAXV);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      div_sel = i[3]; hold = i[5];
      step;
      if (running || irq || count != MAXV) bad++;
    end
    chk(bad == 0, "R1 idle before start", bad, 0);
    hold = 1'b0; div_sel = 1'b0;

    // R2 start, R3 low ratio spacing
    start_pulse;
    chk(running == 1'b1, "R2 running after start", running, 1);
    chk(count == MAXV, "R2 count after start", count, MAXV);
    steps_to_change(n);
    chk(n == DIV_LO, "R3 first decrement low ratio", n, DIV_LO);
    for (int k = 0; k < 3; k++) begin
      steps_to_change(n);
      chk(n == DIV_LO, "R3 decrement spacing low ratio", n, DIV_LO);
      chk(count == MAXV - 2 - k, "R3 decrement value", count, MAXV - 2 - k);
    end

    // R4 interrupt pulse and period
    wait_irq;
    chk(irq == 1'b1, "R4 irq reached", irq, 1);
    chk(count == 0, "R4 count at irq", count, 0);
    step;
    chk(irq == 1'b0, "R4 irq single cycle", irq, 0);
    chk(count == MAXV, "R4 reload on underflow", count, MAXV);
    wait_irq;
    steps_to_irq(n);
    chk(n == DIV_LO * (MAXV + 1), "R4 period low ratio", n, DIV_LO * (MAXV + 1));

    // R6 hold lengthens the period by the hold length
    step; n = 1;
    hold = 1'b1;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      step; n++;
      if (count != MAXV || irq) bad++;
    end
    hold = 1'b0;
    chk(bad == 0, "R6 frozen under hold", bad, 0);
    while (!irq && n < LIMIT) begin step; n++; end
    chk(n == DIV_LO * (MAXV + 1) + 10, "R6 period with hold", n, DIV_LO * (MAXV + 1) + 10);

    // R5 / R7 restart right after a decrement
    step;
    steps_to_change(n);
    steps_to_change(n);
    start_pulse;
    chk(count == MAXV, "R7 restart reloads", count, MAXV);
    chk(running == 1'b1, "R7 still running", running, 1);
    steps_to_change(n);
    chk(n == DIV_LO - 1, "R5 prescaler kept on restart", n, DIV_LO - 1);

    bad = 0;
    for (int i = 0; i < 300; i++) begin
      step;
      if (!running) bad++;
    end
    chk(bad == 0, "R7 cannot stop", bad, 0);

    // R3 / R4 high ratio after a fresh reset
    do_reset;
    chk(running == 1'b0, "R7 reset stops timer", running, 0);
    div_sel = 1'b1;
    start_pulse;
    steps_to_change(n);
    chk(n == DIV_HI, "R3 first decrement high ratio", n, DIV_HI);
    steps_to_change(n);
    chk(n == DIV_HI, "R3 decrement spacing high ratio", n, DIV_HI);
    wait_irq;
    steps_to_irq(n);
    chk(n == DIV_HI * (MAXV + 1), "R4 period high ratio", n, DIV_HI * (MAXV + 1));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule